// File: doc/BRIEF.md
# GPIO Edge and Level Event Detector

This block watches a set of general-purpose input pins and records events on them in sticky status bits. Every pin brings its own six enables. Four of them act on the synchronized input: rising edge, falling edge, high level and low level. The other two act on the earliest synchronizer sample: a fast rising edge and a fast falling edge. When any enabled condition holds for a pin, that pin's status bit is set. The bit then stays set until software clears it by writing a one to it.

The pins are grouped into banks of 32. With the default 54 pins there are two banks, and the second bank holds only 22 pins. Each bank drives its own interrupt line, which is high while any status bit of that bank is set. Software reaches the enables and the status words through a simple register port. A write takes effect on the next clock edge, and a read returns data in the same cycle.

Top module: `gpio_event_unit`

## Requirements
- R1: After reset, every enable word and every status word reads 0, and both interrupt outputs are low.
- R2: The word addresses are as follows. Status is at 0x40, synchronous rising at 0x4C, synchronous falling at 0x58, high level at 0x64, low level at 0x70, fast rising at 0x7C and fast falling at 0x88. The word at +0 covers pins 0..31, with bit n for pin n. The word at +4 covers pins 32 and up, with bit n-32 for pin n. Enable words read back what was written, and any other address reads 0.
- R3: With the synchronous rising enable set, a low-to-high pin change made between two clock edges shows in the status bit after the third following edge, and not after the second.
- R4: The synchronous falling enable catches high-to-low changes with the same latency as R3. With both synchronous edge enables set, the pin catches both directions.
- R5: The fast rising and fast falling enables catch their edge one cycle earlier than R3, so the status bit shows after the second following edge.
- R6: With the high-level enable set, the status bit sets while the synchronized pin is high, and it sets again after a clear for as long as the pin stays high. The low-level enable does the same while the pin is low.
- R7: Writing a 1 to a status bit clears it on the next edge. Writing a 0 leaves the bit unchanged.
- R8: When a detect condition and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: Removing an enable does not clear a status bit that it had already set.
- R10: The interrupt for a bank is high exactly while at least one status bit of that bank is set. Bit 0 of the interrupt output is bank 0 and bit 1 is bank 1.
- R11: Bits above the last implemented pin in the top word always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| irq_o | output | NUM_BANKS | One interrupt line per bank |

## Verification
The collision that matters is a clearing write to a status bit that lands in the same cycle as a new detection on that pin. The bench provokes it in two ways. First, it writes a clear while a high-level enable holds on a pin that is high. Second, it times a clearing write to land on exactly the edge at which a fast rising event latches. In both cases the status bit must read back as set afterwards. A clear issued one cycle away from any detection must leave the bit at 0.

// File: rtl/gpev_pkg.sv
package gpev_pkg;

    localparam int          WORD_W      = 32;
    localparam int          REG_ADDR_W  = 8;
    localparam logic [7:0]  STAT_BASE   = 8'h40;
    localparam int          KIND_STRIDE = 12;
    localparam int          NUM_KINDS   = 7;

    typedef enum logic [2:0] {
        K_STAT  = 3'd0,
        K_RISE  = 3'd1,
        K_FALL  = 3'd2,
        K_HIGH  = 3'd3,
        K_LOW   = 3'd4,
        K_ARISE = 3'd5,
        K_AFALL = 3'd6
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic [1:0] word;
    } reg_sel_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic high;
        logic low;
        logic arise;
        logic afall;
    } det_en_t;

    // Register groups sit KIND_STRIDE bytes apart, one word per bank inside a group.
    function automatic reg_sel_t decode_addr(input logic [REG_ADDR_W-1:0] addr,
                                             input int nbanks);
        reg_sel_t   s;
        logic [7:0] off;
        int         kind;
        int         word;
        s    = '0;
        off  = addr - STAT_BASE;
        kind = int'(off) / KIND_STRIDE;
        word = (int'(off) % KIND_STRIDE) / 4;
        if (addr >= STAT_BASE && addr[1:0] == 2'b00 && kind < NUM_KINDS && word < nbanks) begin
            s.hit  = 1'b1;
            s.kind = reg_kind_e'(kind[2:0]);
            s.word = word[1:0];
        end
        return s;
    endfunction

endpackage

// File: rtl/gpev_sync.sv
module gpev_sync #(
    parameter int W = 54
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] early_o,
    output logic [W-1:0] now_o,
    output logic [W-1:0] last_o
);
    // early_o is the first stage, now_o the settled sample, last_o the one before it.
    always_ff @(posedge clk) begin
        if (rst) begin
            early_o <= '0;
            now_o   <= '0;
            last_o  <= '0;
        end else begin
            early_o <= pin_i;
            now_o   <= early_o;
            last_o  <= now_o;
        end
    end
endmodule

// File: rtl/gpev_regs.sv
module gpev_regs
    import gpev_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int NUM_BANKS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0]     wdata_i,
    input  logic [NUM_PINS-1:0]   status_i,
    output det_en_t               en_o [NUM_PINS],
    output logic [NUM_PINS-1:0]   clr_o,
    output logic [WORD_W-1:0]     rdata_o
);
    localparam int PAD_W = NUM_BANKS * WORD_W;
    localparam int NEN   = NUM_KINDS - 1;

    function automatic logic [PAD_W-1:0] impl_mask();
        logic [PAD_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_PINS; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [PAD_W-1:0] IMPL_MASK = impl_mask();

    reg_sel_t         sel;
    logic [PAD_W-1:0] en_q [NEN];
    logic [PAD_W-1:0] stat_pad;
    logic             stat_wr;

    assign sel     = decode_addr(addr_i, NUM_BANKS);
    assign stat_wr = wr_i && sel.hit && sel.kind == K_STAT;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NEN; k++) en_q[k] <= '0;
        end else begin
            for (int k = 0; k < NEN; k++) begin
                if (wr_i && sel.hit && int'(sel.kind) == k + 1)
                    en_q[k][sel.word*WORD_W +: WORD_W] <=
                        wdata_i & IMPL_MASK[sel.word*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        stat_pad = '0;
        stat_pad[NUM_PINS-1:0] = status_i;
    end

    always_comb begin
        rdata_o = '0;
        if (sel.hit) begin
            if (sel.kind == K_STAT)
                rdata_o = stat_pad[sel.word*WORD_W +: WORD_W];
            else
                rdata_o = en_q[int'(sel.kind) - 1][sel.word*WORD_W +: WORD_W];
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign en_o[i].rise  = en_q[int'(K_RISE)  - 1][i];
        assign en_o[i].fall  = en_q[int'(K_FALL)  - 1][i];
        assign en_o[i].high  = en_q[int'(K_HIGH)  - 1][i];
        assign en_o[i].low   = en_q[int'(K_LOW)   - 1][i];
        assign en_o[i].arise = en_q[int'(K_ARISE) - 1][i];
        assign en_o[i].afall = en_q[int'(K_AFALL) - 1][i];
        assign clr_o[i] = stat_wr && (int'(sel.word) == i / WORD_W) && wdata_i[i % WORD_W];
    end
endmodule

// File: rtl/gpev_status.sv
module gpev_status
    import gpev_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  det_en_t              en_i [NUM_PINS],
    input  logic [NUM_PINS-1:0]  early_i,
    input  logic [NUM_PINS-1:0]  now_i,
    input  logic [NUM_PINS-1:0]  last_i,
    input  logic [NUM_PINS-1:0]  clr_i,
    output logic [NUM_PINS-1:0]  status_o,
    output logic [NUM_BANKS-1:0] irq_o
);
    localparam int PAD_W = NUM_BANKS * WORD_W;

    logic [NUM_PINS-1:0] set;
    logic [PAD_W-1:0]    stat_pad;
    logic [PAD_W-1:0]    set_pad;
    logic [PAD_W-1:0]    clr_pad;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_det
        assign set[i] = (en_i[i].rise  &  now_i[i]   & ~last_i[i])
                      | (en_i[i].fall  & ~now_i[i]   &  last_i[i])
                      | (en_i[i].high  &  now_i[i])
                      | (en_i[i].low   & ~now_i[i])
                      | (en_i[i].arise &  early_i[i] & ~now_i[i])
                      | (en_i[i].afall & ~early_i[i] &  now_i[i]);
    end

    // A detection in the same cycle as a clear keeps the bit set.
    always_ff @(posedge clk) begin
        if (rst) status_o <= '0;
        else     status_o <= (status_o & ~clr_i) | set;
    end

    always_comb begin
        stat_pad = '0;
        set_pad  = '0;
        clr_pad  = '0;
        stat_pad[NUM_PINS-1:0] = status_o;
        set_pad[NUM_PINS-1:0]  = set;
        clr_pad[NUM_PINS-1:0]  = clr_i;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign irq_o[b] = |stat_pad[b*WORD_W +: WORD_W];

        a_r10_irq_rise: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_o[b]) |-> |($past(set_pad[b*WORD_W +: WORD_W])));
        a_r10_irq_fall: assert property (@(posedge clk) disable iff (rst)
            $fell(irq_o[b]) |-> |($past(clr_pad[b*WORD_W +: WORD_W])));
    end

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_o & $past(clr_i & ~set)) == '0));
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set) & ~status_o) == '0));
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_o) & ~status_o & ~$past(clr_i)) == '0));
    a_r3_only_on_detect: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(set)) == '0));
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
    import gpev_pkg::*;
#(
    parameter int NUM_PINS  = 54,
    parameter int NUM_BANKS = (NUM_PINS + 31) / 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]     reg_wdata,
    output logic [WORD_W-1:0]     reg_rdata,
    output logic [NUM_BANKS-1:0]  irq_o
);
    logic [NUM_PINS-1:0] early, now, last;
    logic [NUM_PINS-1:0] status, clr;
    det_en_t             en [NUM_PINS];

    gpev_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pin_i),
        .early_o(early), .now_o(now), .last_o(last)
    );

    gpev_regs #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_regs (
        .clk(clk), .rst(rst), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
        .status_i(status), .en_o(en), .clr_o(clr), .rdata_o(reg_rdata)
    );

    gpev_status #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) u_status (
        .clk(clk), .rst(rst), .en_i(en), .early_i(early), .now_i(now), .last_i(last),
        .clr_i(clr), .status_o(status), .irq_o(irq_o)
    );
endmodule

// File: tb/test_gpio_event_unit.sv
`timescale 1ns/1ps
module test_gpio_event_unit;
    localparam int NP = 54;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NP-1:0] pins = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    item_t q[$];
    item_t it;
    logic [31:0] act;

    always #2.5 clk = ~clk;

    gpio_event_unit #(.NUM_PINS(NP)) i_gpio_event_unit (
        .clk(clk), .rst(rst), .pin_i(pins), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq)
    );

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        if (q.size() != 0) begin
            it  = q.pop_front();
            act = it.is_irq ? {30'b0, irq} : reg_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t x;
        reg_addr = a;
        x.is_irq = 0; x.exp = e; x.tag = tag;
        q.push_back(x);
        step();
    endtask

    task automatic chk_irq(input logic [1:0] e, input string tag);
        item_t x;
        x.is_irq = 1; x.exp = {30'b0, e}; x.tag = tag;
        q.push_back(x);
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step();
        // R1 reset state
        chk(8'h40, 32'h0, "R1 status bank0");
        chk(8'h44, 32'h0, "R1 status bank1");
        chk(8'h4C, 32'h0, "R1 rise enable");
        chk(8'h74, 32'h0, "R1 low enable bank1");
        chk_irq(2'b00, "R1 irq");

        // R2 readback, R11 unimplemented bits
        wr(8'h4C, 32'hA5A5_0003);
        chk(8'h4C, 32'hA5A5_0003, "R2 rise readback");
        chk(8'h3C, 32'h0, "R2 unmapped address");
        wr(8'h68, 32'hFFFF_FFFF);
        chk(8'h68, 32'h003F_FFFF, "R11 high enable bank1 upper bits");
        wr(8'h68, 32'h0);
        wr(8'h4C, 32'h0000_0001);

        // R3 synchronous rising on pin 0
        pins[0] = 1'b1;
        step(2);
        chk(8'h40, 32'h0, "R3 not yet after two edges");
        chk(8'h40, 32'h1, "R3 rising latched");
        chk_irq(2'b01, "R10 bank0 irq");
        wr(8'h40, 32'h0);
        chk(8'h40, 32'h1, "R7 write zero keeps");
        wr(8'h40, 32'h1);
        chk(8'h40, 32'h0, "R7 write one clears");
        chk_irq(2'b00, "R10 irq drops");

        // R4 falling and both edges
        wr(8'h58, 32'h1);
        pins[0] = 1'b0;
        step(4);
        chk(8'h40, 32'h1, "R4 falling latched");
        wr(8'h40, 32'h1);
        pins[0] = 1'b1;
        step(4);
        chk(8'h40, 32'h1, "R4 both edges rising");
        wr(8'h40, 32'h1);
        wr(8'h4C, 32'h0);
        wr(8'h58, 32'h0);
        chk(8'h40, 32'h0, "R4 cleared");

        // R5 fast edges on pin 37 (bank1 bit 5)
        wr(8'h80, 32'h20);
        pins[37] = 1'b1;
        step(2);
        chk(8'h44, 32'h20, "R5 fast rising after two edges");
        chk_irq(2'b10, "R10 bank1 irq only");
        wr(8'h44, 32'h20);
        wr(8'h8C, 32'h20);
        pins[37] = 1'b0;
        step(2);
        chk(8'h44, 32'h20, "R5 fast falling");
        wr(8'h44, 32'h20);
        wr(8'h80, 32'h0);
        wr(8'h8C, 32'h0);
        chk(8'h44, 32'h0, "R5 cleared");

        // R6 high level on pin 4
        wr(8'h64, 32'h10);
        step(3);
        chk(8'h40, 32'h0, "R6 no high event while low");
        pins[4] = 1'b1;
        step(3);
        chk(8'h40, 32'h10, "R6 high level latched");
        wr(8'h40, 32'h10);
        chk(8'h40, 32'h10, "R8 R6 clear loses to held level");
        wr(8'h64, 32'h0);
        step(3);
        chk(8'h40, 32'h10, "R9 kept after enable removed");
        wr(8'h40, 32'h10);
        chk(8'h40, 32'h0, "R7 cleared after level gone");

        // R6 low level on pin 32
        wr(8'h74, 32'h1);
        step();
        chk(8'h44, 32'h1, "R6 low level latched");
        wr(8'h74, 32'h0);
        wr(8'h44, 32'h1);
        chk(8'h44, 32'h0, "R6 low cleared");

        // R8 clear landing on the same edge as a fast rising event (pin 2)
        wr(8'h7C, 32'h4);
        pins[2] = 1'b1;
        step();
        wr(8'h40, 32'h4);
        chk(8'h40, 32'h4, "R8 set wins over clear");
        wr(8'h40, 32'h4);
        chk(8'h40, 32'h0, "R8 later clear");
        chk_irq(2'b00, "R10 all quiet");

        step(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule